// File: doc/BRIEF.md
# Read/Write/Erase Command Gate for a Disc Drive

This block sits between a drive controller's command bus and the drive's read and write-erase circuits. The controller signals a command by pulling an active-low control strobe low and presenting active-low command bits. The block decodes a read request and a write-erase request from those bits. It then allows or blocks each request according to several safety conditions: a drive-fault ("unsafe") flag, a hardware write-protect switch, two mode flip-flops, and a latched seek-home request.

The block also covers three other duties. It latches a seek-home request when the set-cylinder and set-head-and-sector strobes arrive together. It produces a one-clock pulse that clears the attention flag. It multiplexes the seek-check flag onto a status bit.

All inputs are synchronous to `clk`. The read and write-erase enables, the head-select enable and the status bit are combinational from the current inputs and the registered state. The mode flip-flops, the seek-home latch and the attention-clear pulse are registered.

Top module: `rwe_cmd_ctrl`

## Requirements
- R1: With `ctl_n` low, `cmd_n[1]` low and no inhibit active, `rd_en` is high in the same cycle. `rd_en` is low whenever `ctl_n` is high.
- R2: With `ctl_n` low, `cmd_n[0]` and `cmd_n[2]` both low and no inhibit active, `wr_en` is high in the same cycle. If only one of those two bits is low, `wr_en` stays low.
- R3: `rd_en` and `wr_en` are never high together. When both requests decode and write-erase is permitted, only `wr_en` is high.
- R4: While `unsafe` is high, `rd_en`, `wr_en` and `head_sel_en` are all low. While `unsafe` is low, `head_sel_en` is high.
- R5: While `wr_protect` is high, `wr_en` is low and reads are still allowed. A command that decodes as both a read and a write then yields `rd_en` high.
- R6: At a clock edge where `ctl_n` is low, `shift_in` loads the inverse of `cmd_n[3]` and `shift_out` loads the inverse of `cmd_n[4]`. Both hold their values while `ctl_n` is high, and both reset to 0.
- R7: A command that presents `cmd_n[3]` low or `cmd_n[4]` low (a mode flip-flop being set) blocks `rd_en` and `wr_en`. Operations are enabled only when both mode bits are clear.
- R8: At a clock edge where `set_cyl_n` and `set_hs_n` are both low, `seek_home` is set. It stays set until an edge with `home_done` high and no such collision (the set wins over the clear). While `seek_home` is high, `rd_en` and `wr_en` are low.
- R9: `attn_clr` is high for exactly one cycle, in the cycle after the first edge at which `ctl_n` and `cmd_n[7]` are both low. It stays low while that condition persists.
- R10: `status1` equals `seek_check` while `cmd_n[7]` is low, and is 0 while `cmd_n[7]` is high.
- R11: After reset, `shift_in`, `shift_out`, `seek_home` and `attn_clr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_n | input | 1 | Active-low control strobe |
| cmd_n | input | CMD_W (8) | Active-low command bits |
| set_cyl_n | input | 1 | Active-low set-cylinder strobe |
| set_hs_n | input | 1 | Active-low set-head-and-sector strobe |
| unsafe | input | 1 | Drive fault flag, blocks all operations |
| wr_protect | input | 1 | Write-protect switch |
| seek_check | input | 1 | Seek-check flag to report |
| home_done | input | 1 | Clears the seek-home latch |
| rd_en | output | 1 | Read enable |
| wr_en | output | 1 | Write-erase enable |
| head_sel_en | output | 1 | Head selection enable |
| shift_in | output | 1 | Mode flip-flop loaded from command bit 3 |
| shift_out | output | 1 | Mode flip-flop loaded from command bit 4 |
| seek_home | output | 1 | Latched seek-home request |
| attn_clr | output | 1 | One-cycle attention-clear pulse |
| status1 | output | 1 | Multiplexed status bit |

## Verification
The bench builds the block with its default parameters: an 8-bit command bus, two mode flip-flops starting at bit 3, and the status select on bit 7. These defaults place every decoded bit position at the same index the requirements name.

The directed scenarios cover the following:
- every pairing of inhibit with request, including write-protect meeting a combined read-write command;
- a set-and-clear collision on the seek-home latch;
- a qualifier on bit 7 that is held high, which must not re-pulse `attn_clr`.

// File: rtl/rwe_pkg.sv
package rwe_pkg;

  // Decoded request: both bits are active-high.
  typedef struct packed {
    logic rd;
    logic wr;
  } rwe_req_t;

  // Read request: strobe low and read bit low.
  function automatic logic f_read_req(input logic ctl_n, input logic rd_n);
    return !ctl_n && !rd_n;
  endfunction

  // Write-erase request: strobe low and both write bits low.
  function automatic logic f_write_req(input logic ctl_n, input logic wa_n,
                                       input logic wb_n);
    return !ctl_n && !wa_n && !wb_n;
  endfunction

  // Grant with write priority. Read passes only when write is not granted.
  function automatic rwe_req_t f_grant(input rwe_req_t req, input logic ok,
                                       input logic protect);
    rwe_req_t g;
    g.wr = req.wr && ok && !protect;
    g.rd = req.rd && ok && !g.wr;
    return g;
  endfunction

endpackage

// File: rtl/rwe_decode.sv
module rwe_decode
  import rwe_pkg::*;
#(
  parameter int CMD_W     = 8,
  parameter int RD_BIT    = 1,
  parameter int WA_BIT    = 0,
  parameter int WB_BIT    = 2,
  parameter int SHIFT_LSB = 3,
  parameter int NSHIFT    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_n,
  input  logic [CMD_W-1:0] cmd_n,
  input  logic             unsafe,
  input  logic             wr_protect,
  input  logic             seek_home,
  output logic             rd_en,
  output logic             wr_en,
  output logic             head_sel_en,
  output logic             op_ok
);

  rwe_req_t   req;
  rwe_req_t   gnt;
  logic       mode_busy;

  assign req.rd = f_read_req(ctl_n, cmd_n[RD_BIT]);
  assign req.wr = f_write_req(ctl_n, cmd_n[WA_BIT], cmd_n[WB_BIT]);

  // A command that sets either mode flip-flop blocks operations.
  assign mode_busy = !ctl_n && (cmd_n[SHIFT_LSB +: NSHIFT] != {NSHIFT{1'b1}});

  assign op_ok = !unsafe && !mode_busy && !seek_home;
  assign gnt   = f_grant(req, op_ok, wr_protect);

  assign rd_en       = gnt.rd;
  assign wr_en       = gnt.wr;
  assign head_sel_en = !unsafe;

  assert_mutex_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));
  assert_unsafe_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    unsafe |-> (!rd_en && !wr_en && !head_sel_en));
  assert_protect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_protect |-> !wr_en);
  assert_home_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seek_home |-> (!rd_en && !wr_en));
  assert_strobe_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_n |-> (!rd_en && !wr_en));

endmodule

// File: rtl/rwe_shift_regs.sv
module rwe_shift_regs #(
  parameter int CMD_W     = 8,
  parameter int SHIFT_LSB = 3,
  parameter int NSHIFT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_n,
  input  logic [CMD_W-1:0]  cmd_n,
  output logic [NSHIFT-1:0] mode_q
);

  for (genvar i = 0; i < NSHIFT; i++) begin : g_mode
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mode_q[i] <= 1'b0;
      else if (!ctl_n) mode_q[i] <= !cmd_n[SHIFT_LSB + i];
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_n |=> $stable(mode_q));

endmodule

// File: rtl/rwe_home_latch.sv
module rwe_home_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_cyl_n,
  input  logic set_hs_n,
  input  logic home_done,
  output logic seek_home,
  output logic collide
);

  assign collide = !set_cyl_n && !set_hs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seek_home <= 1'b0;
    else if (collide)   seek_home <= 1'b1;
    else if (home_done) seek_home <= 1'b0;
  end

  assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> seek_home);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!collide && home_done) |=> !seek_home);

endmodule

// File: rtl/rwe_attn_pulse.sv
module rwe_attn_pulse #(
  parameter int CMD_W  = 8,
  parameter int ST_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_n,
  input  logic [CMD_W-1:0] cmd_n,
  output logic             attn_clr,
  output logic             attn_cond
);

  logic cond_q;

  assign attn_cond = !ctl_n && !cmd_n[ST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q   <= 1'b0;
      attn_clr <= 1'b0;
    end else begin
      cond_q   <= attn_cond;
      attn_clr <= attn_cond && !cond_q;
    end
  end

  assert_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    attn_clr |=> !attn_clr);
  assert_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(attn_clr) |-> $past(attn_cond));

endmodule

// File: rtl/rwe_cmd_ctrl.sv
module rwe_cmd_ctrl #(
  parameter int CMD_W     = 8,
  parameter int RD_BIT    = 1,
  parameter int WA_BIT    = 0,
  parameter int WB_BIT    = 2,
  parameter int SHIFT_LSB = 3,
  parameter int ST_BIT    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_n,
  input  logic [CMD_W-1:0] cmd_n,
  input  logic             set_cyl_n,
  input  logic             set_hs_n,
  input  logic             unsafe,
  input  logic             wr_protect,
  input  logic             seek_check,
  input  logic             home_done,
  output logic             rd_en,
  output logic             wr_en,
  output logic             head_sel_en,
  output logic             shift_in,
  output logic             shift_out,
  output logic             seek_home,
  output logic             attn_clr,
  output logic             status1
);

  localparam int NSHIFT = 2;

  logic [NSHIFT-1:0] mode_q;
  logic              op_ok;
  logic              collide;
  logic              attn_cond;

  rwe_decode #(
    .CMD_W(CMD_W), .RD_BIT(RD_BIT), .WA_BIT(WA_BIT), .WB_BIT(WB_BIT),
    .SHIFT_LSB(SHIFT_LSB), .NSHIFT(NSHIFT)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .ctl_n(ctl_n), .cmd_n(cmd_n),
    .unsafe(unsafe), .wr_protect(wr_protect), .seek_home(seek_home),
    .rd_en(rd_en), .wr_en(wr_en), .head_sel_en(head_sel_en), .op_ok(op_ok)
  );

  rwe_shift_regs #(
    .CMD_W(CMD_W), .SHIFT_LSB(SHIFT_LSB), .NSHIFT(NSHIFT)
  ) u_mode (
    .clk(clk), .rst_n(rst_n), .ctl_n(ctl_n), .cmd_n(cmd_n), .mode_q(mode_q)
  );

  rwe_home_latch u_home (
    .clk(clk), .rst_n(rst_n), .set_cyl_n(set_cyl_n), .set_hs_n(set_hs_n),
    .home_done(home_done), .seek_home(seek_home), .collide(collide)
  );

  rwe_attn_pulse #(.CMD_W(CMD_W), .ST_BIT(ST_BIT)) u_attn (
    .clk(clk), .rst_n(rst_n), .ctl_n(ctl_n), .cmd_n(cmd_n),
    .attn_clr(attn_clr), .attn_cond(attn_cond)
  );

  assign shift_in  = mode_q[0];
  assign shift_out = mode_q[1];
  assign status1   = !cmd_n[ST_BIT] && seek_check;

  assert_status_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_n[ST_BIT] |-> !status1);
  assert_grant_needs_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) |-> op_ok);

endmodule

// File: tb/rwe_cmd_ctrl_test.sv
`timescale 1ns/1ps
module rwe_cmd_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_n, set_cyl_n, set_hs_n, unsafe, wr_protect, seek_check, home_done;
  logic [7:0] cmd_n;
  logic       rd_en, wr_en, head_sel_en, shift_in, shift_out, seek_home, attn_clr, status1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rwe_cmd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ctl_n(ctl_n), .cmd_n(cmd_n),
    .set_cyl_n(set_cyl_n), .set_hs_n(set_hs_n), .unsafe(unsafe),
    .wr_protect(wr_protect), .seek_check(seek_check), .home_done(home_done),
    .rd_en(rd_en), .wr_en(wr_en), .head_sel_en(head_sel_en),
    .shift_in(shift_in), .shift_out(shift_out), .seek_home(seek_home),
    .attn_clr(attn_clr), .status1(status1)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic idle();
    ctl_n = 1'b1; cmd_n = 8'hFF; set_cyl_n = 1'b1; set_hs_n = 1'b1;
    home_done = 1'b0;
  endtask

  // Drive at the falling edge and let the combinational outputs settle.
  task automatic drive(input logic c, input logic [7:0] cmd);
    @(negedge clk); ctl_n = c; cmd_n = cmd; #1;
  endtask

  task automatic t_reset();
    chk("R11 shift_in", shift_in, 1'b0);
    chk("R11 shift_out", shift_out, 1'b0);
    chk("R11 seek_home", seek_home, 1'b0);
    chk("R11 attn_clr", attn_clr, 1'b0);
  endtask

  task automatic t_read();
    drive(1'b0, 8'b1111_1101);
    chk("R1 read granted", rd_en, 1'b1);
    chk("R1 no write", wr_en, 1'b0);
    drive(1'b1, 8'b1111_1101);
    chk("R1 strobe high no read", rd_en, 1'b0);
  endtask

  task automatic t_write();
    drive(1'b0, 8'b1111_1010);
    chk("R2 write granted", wr_en, 1'b1);
    drive(1'b0, 8'b1111_1110);
    chk("R2 bit0 alone no write", wr_en, 1'b0);
    drive(1'b0, 8'b1111_1011);
    chk("R2 bit2 alone no write", wr_en, 1'b0);
  endtask

  task automatic t_priority();
    drive(1'b0, 8'b1111_1000);
    chk("R3 write wins", wr_en, 1'b1);
    chk("R3 read suppressed", rd_en, 1'b0);
  endtask

  task automatic t_unsafe();
    @(negedge clk); unsafe = 1'b1;
    drive(1'b0, 8'b1111_1101);
    chk("R4 read blocked", rd_en, 1'b0);
    chk("R4 head sel off", head_sel_en, 1'b0);
    drive(1'b0, 8'b1111_1010);
    chk("R4 write blocked", wr_en, 1'b0);
    @(negedge clk); unsafe = 1'b0; #1;
    chk("R4 head sel on", head_sel_en, 1'b1);
  endtask

  task automatic t_protect();
    @(negedge clk); wr_protect = 1'b1;
    drive(1'b0, 8'b1111_1010);
    chk("R5 write blocked", wr_en, 1'b0);
    drive(1'b0, 8'b1111_1000);
    chk("R5 combined gives read", rd_en, 1'b1);
    chk("R5 combined no write", wr_en, 1'b0);
    @(negedge clk); wr_protect = 1'b0;
  endtask

  task automatic t_shift();
    drive(1'b0, 8'b1111_0111);          // set shift_in, read bit high
    chk("R7 mode bit3 blocks", rd_en, 1'b0);
    drive(1'b1, 8'b1110_1111);          // strobe high: holds
    chk("R6 shift_in loaded", shift_in, 1'b1);
    chk("R6 shift_out clear", shift_out, 1'b0);
    drive(1'b1, 8'b1111_1111);
    chk("R6 hold shift_in", shift_in, 1'b1);
    drive(1'b0, 8'b1110_1101);          // read with bit4 low
    chk("R7 mode bit4 blocks read", rd_en, 1'b0);
    drive(1'b1, 8'hFF);
    chk("R6 shift_in cleared", shift_in, 1'b0);
    chk("R6 shift_out loaded", shift_out, 1'b1);
    drive(1'b0, 8'b1111_1101);          // clean read clears both
    chk("R7 clean read passes", rd_en, 1'b1);
    drive(1'b1, 8'hFF);
    chk("R6 shift_out cleared", shift_out, 1'b0);
  endtask

  task automatic t_home();
    @(negedge clk); set_cyl_n = 1'b0; set_hs_n = 1'b1;
    @(negedge clk); #1;
    chk("R8 single strobe no home", seek_home, 1'b0);
    set_hs_n = 1'b0;
    @(negedge clk); set_cyl_n = 1'b1; set_hs_n = 1'b1; #1;
    chk("R8 collision sets", seek_home, 1'b1);
    drive(1'b0, 8'b1111_1101);
    chk("R8 read blocked", rd_en, 1'b0);
    drive(1'b1, 8'hFF);
    chk("R8 held", seek_home, 1'b1);
    @(negedge clk); home_done = 1'b1; set_cyl_n = 1'b0; set_hs_n = 1'b0;
    @(negedge clk); set_cyl_n = 1'b1; set_hs_n = 1'b1; #1;
    chk("R8 set wins over clear", seek_home, 1'b1);
    @(negedge clk); home_done = 1'b0; #1;
    chk("R8 cleared by home_done", seek_home, 1'b0);
    drive(1'b0, 8'b1111_1101);
    chk("R8 read restored", rd_en, 1'b1);
    drive(1'b1, 8'hFF);
  endtask

  task automatic t_attn();
    drive(1'b0, 8'b0111_1111);
    chk("R9 not yet", attn_clr, 1'b0);
    @(negedge clk); #1;
    chk("R9 pulse", attn_clr, 1'b1);
    @(negedge clk); #1;
    chk("R9 one cycle only", attn_clr, 1'b0);
    @(negedge clk); #1;
    chk("R9 held cond no repulse", attn_clr, 1'b0);
    drive(1'b1, 8'hFF);
  endtask

  task automatic t_status();
    @(negedge clk); seek_check = 1'b1; cmd_n = 8'b0111_1111; #1;
    chk("R10 status follows", status1, 1'b1);
    @(negedge clk); seek_check = 1'b0; #1;
    chk("R10 status follows low", status1, 1'b0);
    @(negedge clk); seek_check = 1'b1; cmd_n = 8'hFF; #1;
    chk("R10 status off", status1, 1'b0);
    @(negedge clk); seek_check = 1'b0;
  endtask

  initial begin
    #4000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; idle(); unsafe = 1'b0; wr_protect = 1'b0; seek_check = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    t_reset();
    t_read();
    t_write();
    t_priority();
    t_unsafe();
    t_protect();
    t_shift();
    t_home();
    t_attn();
    t_status();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule